// File: doc/BRIEF.md
# Multi-Level Address Translation Walker

This block turns a 64-bit virtual address into a page-aligned real address by walking a hierarchy of translation tables in memory. The hierarchy can have up to five tables: three region tables (first, second, third), a segment table and a page table. Where the walk starts depends on a type field in the root control element. Each table entry is one 64-bit word. The block fetches each entry over a simple request/acknowledge read port, and only one read is in flight at a time.

A caller supplies the following, then pulses `start`:

- the address;
- the access kind (read, store or instruction fetch);
- the address-space mode;
- three root control elements (primary, secondary, home);
- the extended-translation enable.

The block later pulses `done` for one cycle. At that point it presents either a real address with read, write and execute permissions, or a typed fault with a composed 64-bit exception code.

Every level checks its input before it descends:

- at the root, whether the address fits that level;
- at each level, the table length or offset;
- the entry's invalid and type bits;
- reserved bits in the page entry.

If extended translation is on, a segment entry can end the walk early as a 1 MB frame.

Top module: `xlat_walker`

## Requirements
- R1: When bit 5 (real-space) of the selected root element is set, no memory read is issued, fault is 0 and the real address equals the virtual address with bits 11:0 cleared.
- R2: Before any read, the root type (bits 3:2: 3 region-first, 2 region-second, 1 region-third, 0 segment) sets a fit rule. A region-second root needs virtual bits 63:53 clear, a region-third root needs bits 63:42 clear, and a segment root needs bits 63:31 clear. A violation gives fault code 1 and no read is issued.
- R3: The two top bits of the root level's index are compared with the root length field (bits 1:0). They are virtual bits 63:62, 52:51, 41:40 or 30:29 for region-first, region-second, region-third or segment. If they are greater, the walk ends with no read and a translation fault for that level: code 2 (region-first), 3 (region-second), 4 (region-third) or 5 (segment).
- R4: Each table entry is read at origin + index*8. The index is virtual bits 63:53, 52:42, 41:31, 30:20 or 19:12 for the region-first, region-second, region-third, segment or page table. The root and region entries carry the origin in bits 63:12. One read is made per level from the root level down to the page table.
- R5: A fetched entry with bit 5 set gives the translation fault of the table it was read from (codes 2 to 5). A region or segment entry whose type bits 3:2 differ from that table's level gives code 7.
- R6: A region entry holds an offset in bits 7:6 and a length in bits 1:0. If the top two index bits of the next level are below the offset or above the length, the walk ends with the next level's translation fault.
- R7: A segment entry with bit 10 set ends the walk without a page read when extended translation is enabled. The real address is then entry bits 63:20 joined with virtual bits 19:12 and 12 zero bits. When extended translation is disabled, bit 10 has no effect.
- R8: The page table origin is segment entry bits 63:11. A page entry with bit 10 set gives code 6. A page entry with bit 8 or bit 11 set gives code 7. Otherwise the real address is page entry bits 63:12 with 12 zero bits.
- R9: Bit 9 removes write permission when it is set in the segment entry, in the page entry, or in a region entry while extended translation is enabled. A store (access 1) that reaches a frame without write permission ends with code 8.
- R10: On a fault the exception code is built from four parts, ORed together. The first is the page-aligned virtual address. The second is 0x400 for a store, or 0x800 for a read (access 0) or fetch (access 2). The third is 4 for code 8 only. The fourth is the effective mode value. On success the exception code is 0.
- R11: Modes are 0 or 1 primary, 2 secondary and 3 home; each selects its own root element. In mode 2 a fetch walks the primary element, reports mode value 0 in the code, and gets read and write permission cleared. In mode 2 a data access walks the secondary element and gets execute permission cleared.
- R12: The memory request holds its address stable until acknowledged, the address is 8-byte aligned, and no second read starts before the acknowledge.
- R13: After reset, done and the memory request are 0. Done is high for exactly one cycle per walk, with no memory request in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken when idle) |
| va | input | 64 | Virtual address |
| acc | input | 2 | Access kind: 0 read, 1 store, 2 fetch |
| mode | input | 2 | Address-space mode |
| edat | input | 1 | Extended-translation enable |
| ce_pri | input | 64 | Primary root control element |
| ce_sec | input | 64 | Secondary root control element |
| ce_home | input | 64 | Home root control element |
| mem_req | output | 1 | Table read request |
| mem_addr | output | 64 | Table read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 64 | Table entry read data |
| done | output | 1 | One-cycle completion pulse |
| real_addr | output | 64 | Translated page-aligned real address |
| perm_r | output | 1 | Read permitted |
| perm_w | output | 1 | Write permitted |
| perm_x | output | 1 | Execute permitted |
| fault | output | 1 | Walk ended in a fault |
| fault_type | output | 4 | Fault code (0 none, 1 to 8 as listed) |
| tec | output | 64 | Composed translation exception code |

## Verification
The acknowledge of the final page entry does two things in one cycle: it ends the walk, and it settles the protection decision from the read-only bit carried by that same entry and the write permission gathered so far. A full sweep of read-only bits at the region, segment and page levels is crossed with extended translation on and off and with read or store accesses. The memory model's latency rotates from 0 to 3 cycles, so an acknowledge can also land in the first cycle of a request. Each result is judged by the fault code, the write permission and the exception code's protection bit, all computed arithmetically from the bit combination.

// File: rtl/xw_pkg.sv
package xw_pkg;
    localparam int AW      = 64;
    localparam int PG_SH   = 12;
    localparam int IDX_W   = 11;
    localparam int CE_REAL = 5;
    localparam int E_INV   = 5;
    localparam int E_RO    = 9;
    localparam int E_FC    = 10;
    localparam int P_INV   = 10;
    localparam int P_RES_A = 8;
    localparam int P_RES_B = 11;

    localparam logic [1:0] ACC_RD    = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;
    localparam logic [1:0] MD_SEC    = 2'd2;
    localparam logic [1:0] MD_HOME   = 2'd3;

    typedef enum logic [3:0] {
        F_NONE = 4'd0, F_ASCE = 4'd1, F_RF = 4'd2, F_RS = 4'd3, F_RT = 4'd4,
        F_SEG = 4'd5, F_PAGE = 4'd6, F_SPEC = 4'd7, F_PROT = 4'd8
    } fault_e;

    typedef enum logic [2:0] {
        LV_SEG = 3'd0, LV_R3 = 3'd1, LV_R2 = 3'd2, LV_R1 = 3'd3, LV_PTE = 3'd4
    } lvl_e;

    typedef enum logic [1:0] {S_IDLE, S_CHK, S_READ} st_e;

    typedef struct packed {
        st_e           st;
        lvl_e          lvl;
        logic [AW-1:0] org;
        logic [AW-1:0] va;
        logic [1:0]    acc;
        logic [1:0]    mode;
        logic          edat;
        logic          wr;
        logic [AW-1:0] ce;
        logic          done;
        logic [AW-1:0] ra;
        logic          pr;
        logic          pw;
        logic          px;
        logic          flt;
        fault_e        ft;
        logic [AW-1:0] tec;
    } ws_t;

    function automatic fault_e trans_fault(input lvl_e l);
        case (l)
            LV_R1:   return F_RF;
            LV_R2:   return F_RS;
            LV_R3:   return F_RT;
            LV_SEG:  return F_SEG;
            default: return F_PAGE;
        endcase
    endfunction

    function automatic logic [1:0] top2(input lvl_e l, input logic [AW-1:0] v);
        case (l)
            LV_R1:   return v[63:62];
            LV_R2:   return v[52:51];
            LV_R3:   return v[41:40];
            default: return v[30:29];
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] tidx(input lvl_e l, input logic [AW-1:0] v);
        case (l)
            LV_R1:   return v[63:53];
            LV_R2:   return v[52:42];
            LV_R3:   return v[41:31];
            LV_SEG:  return v[30:20];
            default: return {3'b000, v[19:12]};
        endcase
    endfunction
endpackage

// File: rtl/xw_root_chk.sv
module xw_root_chk
    import xw_pkg::*;
(
    input  logic [63:29] va_hi,
    input  logic [3:0]   ce_lo,
    output logic         bad,
    output fault_e       ftype,
    output lvl_e         lvl
);
    logic [AW-1:0] va_full;

    always_comb begin
        va_full = {va_hi, 29'b0};
        lvl     = lvl_e'({1'b0, ce_lo[3:2]});
        bad     = 1'b0;
        ftype   = F_NONE;
        case (lvl)
            LV_R2:   bad = |va_hi[63:53];
            LV_R3:   bad = |va_hi[63:42];
            LV_SEG:  bad = |va_hi[63:31];
            default: bad = 1'b0;
        endcase
        if (bad) begin
            ftype = F_ASCE;
        end else if (top2(lvl, va_full) > ce_lo[1:0]) begin
            bad   = 1'b1;
            ftype = trans_fault(lvl);
        end
    end
endmodule

// File: rtl/xw_entry_dec.sv
module xw_entry_dec
    import xw_pkg::*;
(
    input  lvl_e          lvl,
    input  logic [AW-1:0] ent,
    input  logic [AW-1:0] va,
    input  logic          edat,
    output logic          bad,
    output fault_e        ftype,
    output logic          last,
    output logic          ro,
    output logic [AW-1:0] next_org,
    output lvl_e          next_lvl,
    output logic [AW-1:0] frame
);
    logic [1:0] nt;
    logic       unused_dec;

    assign unused_dec = ^{ent[4], va};

    always_comb begin
        bad      = 1'b0;
        ftype    = F_NONE;
        last     = 1'b0;
        ro       = 1'b0;
        next_org = '0;
        next_lvl = LV_PTE;
        frame    = '0;
        nt       = 2'b00;
        case (lvl)
            LV_R1:   next_lvl = LV_R2;
            LV_R2:   next_lvl = LV_R3;
            LV_R3:   next_lvl = LV_SEG;
            default: next_lvl = LV_PTE;
        endcase
        if (lvl == LV_PTE) begin
            if (ent[P_INV]) begin
                bad = 1'b1; ftype = F_PAGE;
            end else if (ent[P_RES_A] || ent[P_RES_B]) begin
                bad = 1'b1; ftype = F_SPEC;
            end else begin
                last  = 1'b1;
                ro    = ent[E_RO];
                frame = {ent[63:PG_SH], {PG_SH{1'b0}}};
            end
        end else if (ent[E_INV]) begin
            bad = 1'b1; ftype = trans_fault(lvl);
        end else if (ent[3:2] != lvl[1:0]) begin
            bad = 1'b1; ftype = F_SPEC;
        end else if (lvl == LV_SEG) begin
            ro = ent[E_RO];
            if (ent[E_FC] && edat) begin
                last  = 1'b1;
                frame = {ent[63:20], va[19:12], {PG_SH{1'b0}}};
            end else begin
                next_org = {ent[63:11], 11'b0};
            end
        end else begin
            nt = top2(next_lvl, va);
            if (nt < ent[7:6] || nt > ent[1:0]) begin
                bad = 1'b1; ftype = trans_fault(next_lvl);
            end else begin
                ro       = edat & ent[E_RO];
                next_org = {ent[63:PG_SH], {PG_SH{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [63:0] va,
    input  logic [1:0]  acc,
    input  logic [1:0]  mode,
    input  logic        edat,
    input  logic [63:0] ce_pri,
    input  logic [63:0] ce_sec,
    input  logic [63:0] ce_home,
    output logic        mem_req,
    output logic [63:0] mem_addr,
    input  logic        mem_ack,
    input  logic [63:0] mem_rdata,
    output logic        done,
    output logic [63:0] real_addr,
    output logic        perm_r,
    output logic        perm_w,
    output logic        perm_x,
    output logic        fault,
    output logic [3:0]  fault_type,
    output logic [63:0] tec
);
    ws_t q, d;

    logic          r_bad;
    fault_e        r_ft;
    lvl_e          r_lvl;
    logic          e_bad, e_last, e_ro;
    fault_e        e_ft;
    logic [AW-1:0] e_org, e_frame;
    lvl_e          e_nlvl;

    logic          fin, fin_bad, fin_wr, prot;
    fault_e        fin_ft;
    logic [AW-1:0] fin_ra;
    logic [1:0]    meff;
    logic          unused_top;

    assign unused_top = ^{va[11:0], q.ce[11:6], q.ce[4]};

    xw_root_chk u_root (
        .va_hi (q.va[63:29]),
        .ce_lo (q.ce[3:0]),
        .bad   (r_bad),
        .ftype (r_ft),
        .lvl   (r_lvl)
    );

    xw_entry_dec u_dec (
        .lvl      (q.lvl),
        .ent      (mem_rdata),
        .va       (q.va),
        .edat     (q.edat),
        .bad      (e_bad),
        .ftype    (e_ft),
        .last     (e_last),
        .ro       (e_ro),
        .next_org (e_org),
        .next_lvl (e_nlvl),
        .frame    (e_frame)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        fin     = 1'b0;
        fin_bad = 1'b0;
        fin_ft  = F_NONE;
        fin_ra  = '0;
        fin_wr  = q.wr;
        prot    = 1'b0;
        meff    = (q.mode == MD_SEC && q.acc == ACC_FETCH) ? 2'd0 : q.mode;

        case (q.st)
            S_IDLE: if (start) begin
                d.st   = S_CHK;
                d.va   = {va[63:PG_SH], {PG_SH{1'b0}}};
                d.acc  = acc;
                d.mode = mode;
                d.edat = edat;
                d.wr   = 1'b1;
                if (mode == MD_HOME)
                    d.ce = ce_home;
                else if (mode == MD_SEC && acc != ACC_FETCH)
                    d.ce = ce_sec;
                else
                    d.ce = ce_pri;
            end
            S_CHK: begin
                if (q.ce[CE_REAL]) begin
                    fin    = 1'b1;
                    fin_ra = q.va;
                end else if (r_bad) begin
                    fin     = 1'b1;
                    fin_bad = 1'b1;
                    fin_ft  = r_ft;
                end else begin
                    d.lvl = r_lvl;
                    d.org = {q.ce[63:PG_SH], {PG_SH{1'b0}}};
                    d.st  = S_READ;
                end
            end
            S_READ: if (mem_ack) begin
                if (e_bad) begin
                    fin     = 1'b1;
                    fin_bad = 1'b1;
                    fin_ft  = e_ft;
                end else begin
                    if (e_ro) d.wr = 1'b0;
                    if (e_last) begin
                        fin    = 1'b1;
                        fin_ra = e_frame;
                        fin_wr = q.wr & ~e_ro;
                    end else begin
                        d.lvl = e_nlvl;
                        d.org = e_org;
                    end
                end
            end
            default: d.st = S_IDLE;
        endcase

        if (fin) begin
            d.st   = S_IDLE;
            d.done = 1'b1;
            prot   = !fin_bad && q.acc == ACC_STORE && !fin_wr;
            if (fin_bad || prot) begin
                d.flt = 1'b1;
                d.ft  = prot ? F_PROT : fin_ft;
                d.ra  = '0;
                d.pr  = 1'b0;
                d.pw  = 1'b0;
                d.px  = 1'b0;
                d.tec = {q.va[63:PG_SH], {PG_SH{1'b0}}}
                      | (q.acc == ACC_STORE ? 64'h400 : 64'h800)
                      | (prot ? 64'h4 : 64'h0)
                      | {62'b0, meff};
            end else begin
                d.flt = 1'b0;
                d.ft  = F_NONE;
                d.ra  = fin_ra;
                d.pr  = 1'b1;
                d.pw  = fin_wr;
                d.px  = 1'b1;
                d.tec = '0;
                if (q.mode == MD_SEC) begin
                    if (q.acc == ACC_FETCH) begin
                        d.pr = 1'b0;
                        d.pw = 1'b0;
                    end else begin
                        d.px = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_req    = (q.st == S_READ);
    assign mem_addr   = q.org + {50'b0, tidx(q.lvl, q.va), 3'b000};
    assign done       = q.done;
    assign real_addr  = q.ra;
    assign perm_r     = q.pr;
    assign perm_w     = q.pw;
    assign perm_x     = q.px;
    assign fault      = q.flt;
    assign fault_type = q.ft;
    assign tec        = q.tec;
endmodule

// File: rtl/xw_checker.sv
module xw_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        mem_req,
    input logic [63:0] mem_addr,
    input logic        mem_ack,
    input logic        done,
    input logic        fault,
    input logic [3:0]  fault_type,
    input logic [63:0] tec
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R12
    AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[2:0] == 3'b000); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R13
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R13
    AST_PROT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault && fault_type == 4'd8 |-> tec[2] && tec[10]); // R9
    AST_TEC_FS: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> $countones(tec[11:10]) == 1); // R10
endmodule

bind xlat_walker xw_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_ack    (mem_ack),
    .done       (done),
    .fault      (fault),
    .fault_type (fault_type),
    .tec        (tec)
);

// File: tb/sim_xlat_walker.sv
`timescale 1ns/1ps
module sim_xlat_walker;
    logic        clk = 1'b0;
    logic        rst_n, start, edat, mem_ack, mem_req, done, perm_r, perm_w, perm_x, fault;
    logic [63:0] va, ce_pri, ce_sec, ce_home, mem_addr, mem_rdata, real_addr, tec;
    logic [1:0]  acc, mode;
    logic [3:0]  fault_type;

    always #2 clk = ~clk;

    xlat_walker u0 (.*);

    localparam logic [63:0] RF_B = 64'h10000, RS_B = 64'h20000, RT_B = 64'h30000,
                            SG_B = 64'h40000, PT_B = 64'h50000;

    logic [63:0] mem [logic [63:0]];
    int n_vec = 0, n_bad = 0, reads = 0, lat = 0, wcnt = 0, hold_err = 0, run_no = 0;
    logic [63:0] first_addr, tv, fr, xp, big;
    logic [63:0] alog [0:7];
    bit finished = 0;

    function automatic logic [63:0] rd(input logic [63:0] a);
        return mem.exists(a) ? mem[a] : 64'h0;
    endfunction
    function automatic logic [63:0] e_root(input logic [63:0] o, input int rs, input int ty, input int tl);
        return o | (64'(rs) << 5) | (64'(ty) << 2) | 64'(tl);
    endfunction
    function automatic logic [63:0] e_reg(input logic [63:0] o, input int ty, input int off, input int len);
        return o | (64'(off) << 6) | (64'(ty) << 2) | 64'(len);
    endfunction
    function automatic logic [63:0] ix(input logic [63:0] v, input int sh, input int msk);
        return ((v >> sh) & 64'(msk)) << 3;
    endfunction
    function automatic logic [63:0] a_rf(input logic [63:0] v); return RF_B + ix(v, 53, 'h7ff); endfunction
    function automatic logic [63:0] a_rs(input logic [63:0] v); return RS_B + ix(v, 42, 'h7ff); endfunction
    function automatic logic [63:0] a_rt(input logic [63:0] v); return RT_B + ix(v, 31, 'h7ff); endfunction
    function automatic logic [63:0] a_sg(input logic [63:0] v); return SG_B + ix(v, 20, 'h7ff); endfunction
    function automatic logic [63:0] a_pt(input logic [63:0] v); return PT_B + ix(v, 12, 'hff); endfunction

    task automatic make_chain(input logic [63:0] v, input logic [63:0] f);
        mem.delete();
        mem[a_rf(v)] = e_reg(RS_B, 3, 0, 3);
        mem[a_rs(v)] = e_reg(RT_B, 2, 0, 3);
        mem[a_rt(v)] = e_reg(SG_B, 1, 0, 3);
        mem[a_sg(v)] = PT_B;
        mem[a_pt(v)] = f;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // memory model: latency rotates 0..3, checks request stability
    initial begin
        mem_ack = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (wcnt == 0) first_addr = mem_addr;
                else if (mem_addr !== first_addr) hold_err++;
                if (wcnt >= lat) begin
                    mem_ack = 1'b1; mem_rdata = rd(mem_addr);
                    if (reads < 8) alog[reads] = mem_addr;
                    reads++; wcnt = 0;
                end else wcnt++;
            end
        end
    end

    task automatic run(input logic [63:0] v, input logic [1:0] a, input logic [1:0] m, input logic e,
                       input logic [63:0] cp, input logic [63:0] cs, input logic [63:0] ch);
        int cyc = 0;
        @(negedge clk);
        lat = run_no % 4; run_no++;
        va = v; acc = a; mode = m; edat = e; ce_pri = cp; ce_sec = cs; ce_home = ch;
        reads = 0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && cyc < 100) begin @(negedge clk); cyc++; end
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL R13 walk hung act=0 exp=1");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R13 watchdog act=timeout exp=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; start = 0; va = 0; acc = 0; mode = 0; edat = 0;
        ce_pri = 0; ce_sec = 0; ce_home = 0;
        repeat (3) @(negedge clk);
        chk("R13 reset done", {63'b0, done}, 0);
        chk("R13 reset req", {63'b0, mem_req}, 0);
        rst_n = 1;

        // R1 real-space bypass
        for (int i = 0; i < 4; i++) begin
            tv = {$urandom, $urandom};
            run(tv, 2'(i % 3), 0, 0, 64'h20, 0, 0);
            chk("R1 real", real_addr, tv & ~64'hfff);
            chk("R1 reads", 64'(reads), 0);
            chk("R1 fault", {63'b0, fault}, 0);
        end
        @(negedge clk);
        chk("R13 done pulse", {63'b0, done}, 0);
        chk("R13 idle req", {63'b0, mem_req}, 0);

        // R2 fit rules
        mem.delete();
        run(64'h8000_0000, 0, 0, 0, e_root(SG_B, 0, 0, 3), 0, 0);
        chk("R2 seg fit", 64'(fault_type), 1); chk("R2 seg reads", 64'(reads), 0);
        run(64'h1 << 42, 0, 0, 0, e_root(RT_B, 0, 1, 3), 0, 0);
        chk("R2 r3 fit", 64'(fault_type), 1);
        run(64'h1 << 53, 0, 0, 0, e_root(RS_B, 0, 2, 3), 0, 0);
        chk("R2 r2 fit", 64'(fault_type), 1);
        run(64'h4000_0000, 0, 0, 0, e_root(SG_B, 0, 0, 3), 0, 0);
        chk("R2 seg edge ok", 64'(fault_type), 0);

        // R3 root length sweeps
        for (int tl = 0; tl < 4; tl++)
            for (int t = 0; t < 4; t++) begin
                mem.delete();
                run(64'(t) << 29, 0, 0, 0, e_root(SG_B, 0, 0, tl), 0, 0);
                chk("R3 seg length", 64'(fault_type), (t > tl) ? 5 : 0);
                run(64'(t) << 62, 0, 0, 0, e_root(RF_B, 0, 3, tl), 0, 0);
                chk("R3 rf length", 64'(fault_type), (t > tl) ? 2 : 7);
                if (t > tl) chk("R3 no read", 64'(reads), 0);
            end

        // R4 full walks from each root type
        for (int r = 0; r < 4; r++) begin
            tv = {$urandom, $urandom};
            if (r == 1) tv = tv & ((64'h1 << 53) - 1);
            if (r == 2) tv = tv & ((64'h1 << 42) - 1);
            if (r == 3) tv = tv & ((64'h1 << 31) - 1);
            fr = {$urandom, $urandom} & ~64'hfff;
            make_chain(tv, fr);
            xp = (r == 0) ? e_root(RF_B, 0, 3, 3) : (r == 1) ? e_root(RS_B, 0, 2, 3) :
                 (r == 2) ? e_root(RT_B, 0, 1, 3) : e_root(SG_B, 0, 0, 3);
            run(tv, 0, 0, 0, xp, 0, 0);
            chk("R4 real", real_addr, fr);
            chk("R4 reads", 64'(reads), 64'(5 - r));
            chk("R4 first addr", alog[0], (r == 0) ? a_rf(tv) : (r == 1) ? a_rs(tv) :
                                          (r == 2) ? a_rt(tv) : a_sg(tv));
            chk("R4 page addr", alog[4 - r], a_pt(tv));
        end

        // R5 invalid per level and type mismatch
        tv = {$urandom, $urandom};
        for (int l = 0; l < 4; l++) begin
            make_chain(tv, 64'h7000);
            xp = (l == 0) ? a_rf(tv) : (l == 1) ? a_rs(tv) : (l == 2) ? a_rt(tv) : a_sg(tv);
            mem[xp] = mem[xp] | 64'h20;
            run(tv, 0, 0, 0, e_root(RF_B, 0, 3, 3), 0, 0);
            chk("R5 invalid code", 64'(fault_type), 64'(2 + l));
            chk("R5 invalid reads", 64'(reads), 64'(l + 1));
        end
        make_chain(tv, 64'h7000);
        mem[a_rs(tv)] = e_reg(RT_B, 1, 0, 3);
        run(tv, 0, 0, 0, e_root(RF_B, 0, 3, 3), 0, 0);
        chk("R5 type mismatch", 64'(fault_type), 7);

        // R6 region offset/length sweep
        for (int o = 0; o < 4; o++)
            for (int l = 0; l < 4; l++)
                for (int t = 0; t < 4; t++) begin
                    tv = (({$urandom, $urandom} & ((64'h1 << 42) - 1)) & ~(64'h3 << 29)) | (64'(t) << 29);
                    make_chain(tv, 64'h9000);
                    mem[a_rt(tv)] = e_reg(SG_B, 1, o, l);
                    run(tv, 0, 0, 0, e_root(RT_B, 0, 1, 3), 0, 0);
                    chk("R6 offset/length", 64'(fault_type), (t < o || t > l) ? 5 : 0);
                end

        // R7 large page
        tv = {$urandom, $urandom};
        big = {$urandom, $urandom} & ~64'hfffff;
        make_chain(tv, 64'h5000);
        mem[a_sg(tv)] = big | 64'h400;
        run(tv, 0, 0, 1, e_root(RF_B, 0, 3, 3), 0, 0);
        chk("R7 large real", real_addr, big | (tv & 64'hff000));
        chk("R7 large reads", 64'(reads), 4);
        run(tv, 0, 0, 0, e_root(RF_B, 0, 3, 3), 0, 0);
        chk("R7 disabled reads", 64'(reads), 5);
        chk("R7 disabled real", real_addr, 0);

        // R8 page entry
        tv = {$urandom, $urandom};
        for (int k = 0; k < 3; k++) begin
            make_chain(tv, 64'h3000 | ((k == 0) ? 64'h400 : (k == 1) ? 64'h100 : 64'h800));
            run(tv, 0, 0, 0, e_root(RF_B, 0, 3, 3), 0, 0);
            chk("R8 page entry code", 64'(fault_type), (k == 0) ? 6 : 7);
        end

        // R9 read-only sweep
        for (int c = 0; c < 32; c++) begin
            logic rt_ro, sg_ro, pt_ro, ee, st, roe;
            {ee, rt_ro, sg_ro, pt_ro, st} = 5'(c);
            tv = {$urandom, $urandom};
            make_chain(tv, 64'hA000);
            if (rt_ro) mem[a_rt(tv)] = mem[a_rt(tv)] | 64'h200;
            if (sg_ro) mem[a_sg(tv)] = mem[a_sg(tv)] | 64'h200;
            if (pt_ro) mem[a_pt(tv)] = mem[a_pt(tv)] | 64'h200;
            roe = sg_ro | pt_ro | (ee & rt_ro);
            run(tv, {1'b0, st}, 0, ee, e_root(RF_B, 0, 3, 3), 0, 0);
            chk("R9 protection", 64'(fault_type), (st && roe) ? 8 : 0);
            if (!(st && roe)) chk("R9 write perm", {63'b0, perm_w}, {63'b0, !roe});
            else chk("R10 prot code", tec, (tv & ~64'hfff) | 64'h404);
        end

        // R10 exception code composition
        mem.delete();
        run(64'h8000_0123, 1, 0, 0, e_root(SG_B, 0, 0, 3), 0, 0);
        chk("R10 store code", tec, 64'h8000_0400);
        run(64'h8000_5000, 0, 3, 0, 0, 0, e_root(SG_B, 0, 0, 3));
        chk("R10 home code", tec, 64'h8000_5803);
        run(64'h9000_0000, 2, 2, 0, e_root(SG_B, 0, 0, 3), 64'h20, 0);
        chk("R10 sec fetch code", tec, 64'h9000_0800);
        run(64'hA000_0000, 0, 2, 0, 64'h20, e_root(SG_B, 0, 0, 3), 0);
        chk("R10 sec data code", tec, 64'hA000_0802);
        run(64'h1000, 0, 0, 0, 64'h20, 0, 0);
        chk("R10 success code", tec, 0);

        // R11 address-space modes
        tv = {$urandom, $urandom};
        fr = {$urandom, $urandom} & ~64'hfff;
        make_chain(tv, fr);
        run(tv, 2, 2, 0, e_root(RF_B, 0, 3, 3), 64'h20, 0);
        chk("R11 sec fetch real", real_addr, fr);
        chk("R11 sec fetch reads", 64'(reads), 5);
        chk("R11 sec fetch perms", {61'b0, perm_r, perm_w, perm_x}, 1);
        run(tv, 0, 2, 0, e_root(RF_B, 0, 3, 3), 64'h20, 0);
        chk("R11 sec data real", real_addr, tv & ~64'hfff);
        chk("R11 sec data perms", {61'b0, perm_r, perm_w, perm_x}, 6);
        mem[a_pt(tv)] = fr | 64'h200;
        run(tv, 1, 2, 0, 64'h20, e_root(RF_B, 0, 3, 3), 0);
        chk("R11 sec store walk", 64'(fault_type), 8);
        run(tv, 0, 3, 0, e_root(RF_B, 0, 3, 3), 0, 64'h20);
        chk("R11 home reads", 64'(reads), 0);
        run(tv, 0, 1, 0, e_root(RF_B, 0, 3, 3), 64'h20, 64'h20);
        chk("R11 mode1 primary", 64'(reads), 5);

        // R12 handshake stability across all runs
        chk("R12 request held", 64'(hold_err), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule